// File: doc/BRIEF.md
# Shared Memory Controller Register Gate

This block is the register-file front end of a non-volatile memory controller that several bus masters share. It sits behind a single-cycle AHB-Lite-style slave port. Each transfer carries the issuing master's ID. The address and control are captured in the address phase, and the write data and the read data belong to the following data phase, with no wait states. Only the low 9 bits of the address are decoded.

Masters compete for an ownership token through a request register at offset 0x100. The rules are:
- Writing 1 to the request register claims the token when it is free.
- Writing 0 to the request register gives the token back.
- Reading the request register shows the caller whether it holds the token.
- The privileged system master, identified by a parameter, can take the token from anyone by writing 3.
- The owner alone may write the command register at 0x104 and read it back.
- The owner alone may read the assembly buffer window at 0x000–0x07F. Its contents come from an external read port.

A 32-word write data buffer at 0x080–0x0FF is open to every master and is wiped when the mode input leaves normal mode. A busy status word at 0x120 reflects per-bank busy inputs.

Top module: `nvm_regbank_gate`

## Requirements
- R1: A request-register (0x100) write of 1 while no master holds the token grants it to the writer. A read of 0x100 then returns bit 0 set for that master.
- R2: A request write of 1 while another master holds the token changes nothing. The requester reads bit 0 as 0.
- R3: The owner writing 0 to 0x100 frees the token. A write of 0 from any other master leaves ownership unchanged.
- R4: A write of 3 to 0x100 from the system master ID makes the system master the owner at once, whoever held the token. Request readback bit 1 is then set for every reader, and bit 0 is set only for the system master. A write of 3 from any other ID is ignored.
- R5: Writes to the command register (0x104) from a non-owner are dropped. Reads of it by a non-owner return zero, and reads by the owner return the last owner-written value.
- R6: A read at 0x000–0x07F by the owner returns the assembly read port data for word index address[6:2]. The same read by a non-owner returns zero.
- R7: The write data buffer at 0x080–0x0FF (word index address[6:2]) is written and read by any master, and holds zero after reset.
- R8: In the cycle the normal-mode input falls, every write buffer word is cleared, and this clear overrides a buffer write committing in that same cycle.
- R9: A system-master takeover (R4) leaves the write buffer contents unchanged.
- R10: A read of 0x120 by any master returns the bank busy inputs in bits [1:0] (bit n for bank n) and zero in bits [31:2].
- R11: Reads of unmapped offsets return zero, and writes to them change no readable state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Address phase valid |
| bus_write | input | 1 | Address phase write flag |
| bus_addr | input | 9 | Address phase byte offset |
| bus_mid | input | 4 | Address phase master ID |
| bus_wdata | input | 32 | Data phase write data |
| bus_rdata | output | 32 | Data phase read data |
| mode_normal | input | 1 | High while the controller is in normal mode |
| bank_busy | input | 2 | Per-bank busy flags |
| asm_idx | output | 5 | Assembly buffer word index being read |
| asm_rdata | input | 32 | Assembly buffer word at asm_idx |

## Verification
The assertions assume the following about the inputs:
- Offsets are word aligned.
- Write data is presented only in the data phase that follows its address phase.
- Busy and assembly data are stable through that data phase.

The bench issues one transfer at a time with aligned offsets. It draws masters from three ordinary IDs plus the system ID, and draws request values from 0, 1, 3 and random words. It holds normal mode high except in the directed clearing case, where the mode input is dropped in the same data phase as a buffer write.

// File: rtl/nvm_gate_pkg.sv
package nvm_gate_pkg;
  localparam int OFF_W = 9;

  typedef enum logic [2:0] {
    RG_ASM, RG_WDB, RG_REQ, RG_CMD, RG_STAT, RG_NONE
  } region_e;

  localparam logic [OFF_W-1:0] OFF_REQ  = 9'h100;
  localparam logic [OFF_W-1:0] OFF_CMD  = 9'h104;
  localparam logic [OFF_W-1:0] OFF_STAT = 9'h120;

  function automatic region_e decode_off(input logic [OFF_W-1:0] off);
    if (off < 9'h080)       return RG_ASM;
    else if (off < 9'h100)  return RG_WDB;
    else if (off == OFF_REQ)  return RG_REQ;
    else if (off == OFF_CMD)  return RG_CMD;
    else if (off == OFF_STAT) return RG_STAT;
    else return RG_NONE;
  endfunction

  function automatic logic [1:0] req_view(input logic held, input logic by_sys,
                                          input logic by_me);
    return {held & by_sys, held & by_me};
  endfunction
endpackage

// File: rtl/nvm_own_fsm.sv
module nvm_own_fsm #(
  parameter int ID_W   = 4,
  parameter int DATA_W = 32,
  parameter logic [ID_W-1:0] SYS_ID = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_we,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [ID_W-1:0]   req_mid,
  output logic              held,
  output logic [ID_W-1:0]   holder,
  output logic              by_sys
);
  logic is_sys, preempt_ev, grant_ev, release_ev;

  assign is_sys     = (req_mid == SYS_ID);
  assign preempt_ev = req_we && (req_wdata == DATA_W'(3)) && is_sys;
  assign grant_ev   = req_we && (req_wdata == DATA_W'(1)) && !held;
  assign release_ev = req_we && (req_wdata == '0) && held && (holder == req_mid);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held   <= 1'b0;
      holder <= '0;
      by_sys <= 1'b0;
    end else if (preempt_ev) begin
      held   <= 1'b1;
      holder <= SYS_ID;
      by_sys <= 1'b1;
    end else if (grant_ev) begin
      held   <= 1'b1;
      holder <= req_mid;
      by_sys <= 1'b0;
    end else if (release_ev) begin
      held   <= 1'b0;
      by_sys <= 1'b0;
    end
  end

  assert_grant_free_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_ev && !preempt_ev) |=> (held && holder == $past(req_mid)));

  assert_deny_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_we && req_wdata == DATA_W'(1) && held && holder != req_mid && !is_sys)
      |=> (held && $stable(holder)));

  assert_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (release_ev && !preempt_ev && !grant_ev) |=> !held);

  assert_takeover_R4: assert property (@(posedge clk) disable iff (!rst_n)
    preempt_ev |=> (held && by_sys && holder == SYS_ID));
endmodule

// File: rtl/nvm_wdbuf.sv
module nvm_wdbuf #(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic              clr,
  input  logic [IDX_W-1:0]  ridx,
  output logic [DATA_W-1:0] rdata,
  output logic              all_zero
);
  logic [DATA_W-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              mem[g] <= '0;
      else if (clr)                            mem[g] <= '0;
      else if (we && widx == IDX_W'(g))        mem[g] <= wdata;
    end
  end

  assign rdata = mem[ridx];

  always_comb begin
    all_zero = 1'b1;
    for (int i = 0; i < DEPTH; i++) if (mem[i] != '0) all_zero = 1'b0;
  end

  assert_mode_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> all_zero);
endmodule

// File: rtl/nvm_regbank_gate.sv
module nvm_regbank_gate
  import nvm_gate_pkg::*;
#(
  parameter int ID_W      = 4,
  parameter int DATA_W    = 32,
  parameter int NBANK     = 2,
  parameter int BUF_DEPTH = 32,
  parameter logic [ID_W-1:0] SYS_ID = '1,
  localparam int IDX_W = $clog2(BUF_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_write,
  input  logic [OFF_W-1:0]  bus_addr,
  input  logic [ID_W-1:0]   bus_mid,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              mode_normal,
  input  logic [NBANK-1:0]  bank_busy,
  output logic [IDX_W-1:0]  asm_idx,
  input  logic [DATA_W-1:0] asm_rdata
);
  logic              dp_valid, dp_write;
  logic [OFF_W-1:0]  dp_off;
  logic [ID_W-1:0]   dp_mid;
  logic [DATA_W-1:0] cmd_q;
  logic              mode_prev;
  region_e           rg;
  logic              held, by_sys, is_owner;
  logic [ID_W-1:0]   holder;
  logic              mode_fall, wdb_we, req_we, cmd_we;
  logic [IDX_W-1:0]  word_idx;
  logic [DATA_W-1:0] wdb_rdata;
  logic              wdb_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dp_valid <= 1'b0;
      dp_write <= 1'b0;
      dp_off   <= '0;
      dp_mid   <= '0;
    end else begin
      dp_valid <= bus_sel;
      dp_write <= bus_write;
      dp_off   <= bus_addr;
      dp_mid   <= bus_mid;
    end
  end

  assign rg       = decode_off(dp_off);
  assign word_idx = dp_off[IDX_W+1:2];
  assign asm_idx  = word_idx;
  assign is_owner = held && (holder == dp_mid);
  assign wdb_we   = dp_valid && dp_write && rg == RG_WDB;
  assign req_we   = dp_valid && dp_write && rg == RG_REQ;
  assign cmd_we   = dp_valid && dp_write && rg == RG_CMD && is_owner;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_prev <= 1'b0;
    else        mode_prev <= mode_normal;
  end
  assign mode_fall = mode_prev && !mode_normal;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmd_q <= '0;
    else if (cmd_we) cmd_q <= bus_wdata;
  end

  nvm_own_fsm #(.ID_W(ID_W), .DATA_W(DATA_W), .SYS_ID(SYS_ID)) u_own (
    .clk(clk), .rst_n(rst_n), .req_we(req_we), .req_wdata(bus_wdata),
    .req_mid(dp_mid), .held(held), .holder(holder), .by_sys(by_sys)
  );

  nvm_wdbuf #(.DEPTH(BUF_DEPTH), .DATA_W(DATA_W)) u_wdb (
    .clk(clk), .rst_n(rst_n), .we(wdb_we), .widx(word_idx), .wdata(bus_wdata),
    .clr(mode_fall), .ridx(word_idx), .rdata(wdb_rdata), .all_zero(wdb_zero)
  );

  always_comb begin
    bus_rdata = '0;
    if (dp_valid && !dp_write) begin
      unique case (rg)
        RG_ASM:  bus_rdata = is_owner ? asm_rdata : '0;
        RG_WDB:  bus_rdata = wdb_rdata;
        RG_REQ:  bus_rdata = DATA_W'(req_view(held, by_sys, is_owner));
        RG_CMD:  bus_rdata = is_owner ? cmd_q : '0;
        RG_STAT: bus_rdata = DATA_W'(bank_busy);
        default: bus_rdata = '0;
      endcase
    end
  end

  assert_cmd_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_valid && dp_write && rg == RG_CMD && !is_owner) |=> $stable(cmd_q));

  assert_asm_hidden_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_valid && !dp_write && rg == RG_ASM && !is_owner) |-> bus_rdata == '0);

  assert_takeover_keeps_buf_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_we && dp_mid == SYS_ID && !mode_fall && !wdb_we && wdb_zero) |=> wdb_zero);

  assert_status_upper_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_valid && !dp_write && rg == RG_STAT) |-> bus_rdata[DATA_W-1:NBANK] == '0);

  assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_valid && rg == RG_NONE) |-> bus_rdata == '0);
endmodule

// File: tb/test_nvm_regbank_gate.sv
module test_nvm_regbank_gate;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] SYS = 4'hF;

  logic        clk = 0, rst_n = 0;
  logic        bus_sel = 0, bus_write = 0;
  logic [8:0]  bus_addr = '0;
  logic [3:0]  bus_mid = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        mode_normal = 1;
  logic [1:0]  bank_busy = '0;
  logic [4:0]  asm_idx;
  logic [31:0] asm_rdata;

  int checks = 0, errors = 0;
  bit done = 0;

  logic        m_held, m_sys;
  logic [3:0]  m_holder;
  logic [31:0] m_cmd;
  logic [31:0] m_wdb [32];

  function automatic logic [31:0] asm_pat(input logic [4:0] i);
    return 32'hC0DE_0000 ^ ({27'd0, i} * 32'h0101_0101);
  endfunction
  assign asm_rdata = asm_pat(asm_idx);

  nvm_regbank_gate i_nvm_regbank_gate (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_mid(bus_mid), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .mode_normal(mode_normal), .bank_busy(bank_busy),
    .asm_idx(asm_idx), .asm_rdata(asm_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic xfer(input logic wr, input logic [8:0] off, input logic [3:0] mid,
                      input logic [31:0] d, input logic drop_mode, output logic [31:0] rd);
    @(negedge clk);
    bus_sel = 1; bus_write = wr; bus_addr = off; bus_mid = mid; bus_wdata = '0;
    @(negedge clk);
    bus_sel = 0; bus_wdata = d;
    if (drop_mode) mode_normal = 0;
    #1 rd = bus_rdata;
  endtask

  function automatic logic [31:0] exp_read(input logic [8:0] off, input logic [3:0] mid);
    logic own = m_held && m_holder == mid;
    if (off < 9'h080) return own ? asm_pat(off[6:2]) : 32'd0;
    if (off < 9'h100) return m_wdb[off[6:2]];
    if (off == 9'h100) return {30'd0, m_held & m_sys, own};
    if (off == 9'h104) return own ? m_cmd : 32'd0;
    if (off == 9'h120) return {30'd0, bank_busy};
    return 32'd0;
  endfunction

  task automatic model_write(input logic [8:0] off, input logic [3:0] mid, input logic [31:0] d);
    if (off >= 9'h080 && off < 9'h100) m_wdb[off[6:2]] = d;
    else if (off == 9'h100) begin
      if (d == 32'd3 && mid == SYS) begin m_held = 1; m_holder = SYS; m_sys = 1; end
      else if (d == 32'd1 && !m_held) begin m_held = 1; m_holder = mid; m_sys = 0; end
      else if (d == 32'd0 && m_held && m_holder == mid) begin m_held = 0; m_sys = 0; end
    end else if (off == 9'h104 && m_held && m_holder == mid) m_cmd = d;
  endtask

  task automatic wr(input logic [8:0] off, input logic [3:0] mid, input logic [31:0] d);
    logic [31:0] rd;
    xfer(1, off, mid, d, 0, rd);
    model_write(off, mid, d);
  endtask

  task automatic rdchk(input string req, input logic [8:0] off, input logic [3:0] mid,
                       input logic [31:0] exp);
    logic [31:0] rd;
    xfer(0, off, mid, 32'd0, 0, rd);
    check(req, rd, exp);
  endtask

  initial begin
    logic [31:0] rd;
    void'($urandom(32'h5EED_1234));
    m_held = 0; m_sys = 0; m_holder = '0; m_cmd = '0;
    for (int i = 0; i < 32; i++) m_wdb[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    rdchk("R10 reset status", 9'h120, 4'd3, 32'd0);
    rdchk("R7 reset buffer", 9'h094, 4'd1, 32'd0);
    rdchk("R1 reset request view", 9'h100, 4'd1, 32'd0);

    wr(9'h100, 4'd1, 32'd1);
    rdchk("R1 grant when free", 9'h100, 4'd1, 32'd1);
    wr(9'h100, 4'd2, 32'd1);
    rdchk("R2 denied requester", 9'h100, 4'd2, 32'd0);
    rdchk("R2 owner kept", 9'h100, 4'd1, 32'd1);

    wr(9'h104, 4'd2, 32'hDEAD_BEEF);
    rdchk("R5 non-owner write dropped", 9'h104, 4'd1, 32'd0);
    wr(9'h104, 4'd1, 32'h0000_1234);
    rdchk("R5 owner readback", 9'h104, 4'd1, 32'h0000_1234);
    rdchk("R5 non-owner read zero", 9'h104, 4'd2, 32'd0);

    rdchk("R6 owner assembly read", 9'h00C, 4'd1, asm_pat(5'd3));
    rdchk("R6 non-owner assembly read", 9'h00C, 4'd2, 32'd0);

    wr(9'h09C, 4'd2, 32'hA1B2_C3D4);
    rdchk("R7 buffer shared", 9'h09C, 4'd3, 32'hA1B2_C3D4);

    wr(9'h100, 4'd3, 32'd0);
    rdchk("R3 non-owner release ignored", 9'h100, 4'd1, 32'd1);
    wr(9'h100, 4'd1, 32'd0);
    rdchk("R3 release by owner", 9'h100, 4'd1, 32'd0);
    wr(9'h100, 4'd2, 32'd1);
    rdchk("R1 grant after release", 9'h100, 4'd2, 32'd1);

    wr(9'h100, 4'd1, 32'd3);
    rdchk("R4 non-system takeover ignored", 9'h100, 4'd2, 32'd1);
    wr(9'h100, SYS, 32'd3);
    rdchk("R4 system takeover", 9'h100, SYS, 32'd3);
    rdchk("R4 preempted view", 9'h100, 4'd2, 32'd2);
    rdchk("R9 buffer kept on takeover", 9'h09C, 4'd3, 32'hA1B2_C3D4);

    bank_busy = 2'b10;
    rdchk("R10 status bank1", 9'h120, 4'd3, 32'd2);
    bank_busy = 2'b01;
    rdchk("R10 status bank0", 9'h120, 4'd1, 32'd1);

    wr(9'h140, 4'd1, 32'hFFFF_FFFF);
    rdchk("R11 unmapped read", 9'h140, 4'd1, 32'd0);
    rdchk("R11 buffer unchanged by unmapped write", 9'h09C, 4'd1, 32'hA1B2_C3D4);

    wr(9'h0A4, 4'd1, 32'h5555_AAAA);
    xfer(1, 9'h0A8, 4'd2, 32'h1234_5678, 1, rd);
    for (int i = 0; i < 32; i++) m_wdb[i] = '0;
    rdchk("R8 cleared on mode fall", 9'h0A4, 4'd1, 32'd0);
    rdchk("R8 clear beats write", 9'h0A8, 4'd1, 32'd0);
    rdchk("R8 older word cleared", 9'h09C, 4'd1, 32'd0);
    mode_normal = 1;

    wr(9'h100, SYS, 32'd0);
    rdchk("R3 system release", 9'h100, SYS, 32'd0);

    for (int n = 0; n < 600; n++) begin
      logic [3:0]  mid;
      logic [8:0]  off;
      logic [31:0] d;
      logic        w;
      int sel;
      sel = $urandom_range(0, 3);
      mid = (sel == 3) ? SYS : 4'(sel + 1);
      bank_busy = 2'($urandom_range(0, 3));
      case ($urandom_range(0, 5))
        0: off = {2'b00, 5'($urandom_range(0, 31)), 2'b00};
        1: off = {2'b01, 5'($urandom_range(0, 31)), 2'b00};
        2: off = 9'h100;
        3: off = 9'h104;
        4: off = 9'h120;
        default: off = 9'h124 + {2'b00, 5'($urandom_range(0, 30)), 2'b00};
      endcase
      w = 1'($urandom_range(0, 1));
      if (off == 9'h100)
        case ($urandom_range(0, 3))
          0: d = 32'd0;
          1: d = 32'd1;
          2: d = 32'd3;
          default: d = $urandom;
        endcase
      else d = $urandom;
      if (w) wr(off, mid, d);
      else begin
        xfer(0, off, mid, 32'd0, 0, rd);
        if (off == 9'h100) check("R1 R2 R3 R4 random request view", rd, exp_read(off, mid));
        else if (off == 9'h104) check("R5 random command read", rd, exp_read(off, mid));
        else if (off < 9'h080) check("R6 random assembly read", rd, exp_read(off, mid));
        else if (off < 9'h100) check("R7 random buffer read", rd, exp_read(off, mid));
        else if (off == 9'h120) check("R10 random status read", rd, exp_read(off, mid));
        else check("R11 random unmapped read", rd, exp_read(off, mid));
      end
    end

    repeat (2) @(negedge clk);
    summary();
  end
endmodule